// File: doc/BRIEF.md
# Dual-Direction Latch/Register Data Port

This block moves a 16-bit word between an A side and a B side, in each direction separately. Each direction has three controls: a high-impedance request, a pass control and a capture strobe. While pass is high, the direction's storage follows its input, so the output tracks the input. While pass is low, the storage holds its value. It loads a new word only when the strobe goes from low to high. Because the strobe is sampled, the value held after pass falls depends on the strobe level at that moment. If the strobe is already high, the storage keeps the last word it passed. If the strobe is low, its next rise captures a fresh word.

The block runs on one system clock with a synchronous active-high reset. The pass and strobe controls are sampled on that clock. The stored words and the drive indications are registered, so every effect appears at the ports one clock after the control is sampled. The high-impedance state is not modelled with an inout pin. Instead, each direction has a drive output beside its data output, and a pad ring or wrapper uses it as the tri-state enable. The B-to-A direction is an identical copy of the A-to-B direction with its own controls.

Top module: `bidir_latch_port`

## Requirements
- R1: During and after reset, both data outputs read 0 and both drive outputs are low until a direction is enabled.
- R2: One clock after its high-impedance request is sampled high, a direction's drive output is low, whatever the other controls are.
- R3: One clock after its high-impedance request is sampled low, a direction's drive output is high.
- R4: When pass is sampled high, the direction's data output equals the sampled input one clock later.
- R5: When pass is sampled low and the strobe is sampled high after being sampled low on the previous clock, the data output equals the sampled input one clock later.
- R6: When pass is low and the strobe is sampled at the same level as on the previous clock (high or low), the data output keeps its value however the input changes.
- R7: If pass falls while the strobe is high, the output keeps the last word passed. Only a later low-then-high strobe loads a new word.
- R8: If pass falls while the strobe is low, the next strobe rise captures the input present at that rise.
- R9: Each direction's controls and input have no effect on the other direction's data and drive outputs.
- R10: The strobe is treated as high at reset. A strobe held high through and after reset captures nothing until it has been seen low.
- R11: Storage keeps loading while the high-impedance request is high. A word passed or captured while the direction is not driving appears on the data output at once, and is still there when driving resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 16 | Word arriving on the A side |
| ab_hiz | input | 1 | A-to-B high-impedance request (high = B side not driven) |
| ab_pass | input | 1 | A-to-B pass control (high = transparent) |
| ab_strobe | input | 1 | A-to-B capture strobe (low-to-high loads while pass is low) |
| b_out | output | 16 | Word presented to the B side |
| drive_b | output | 1 | Tri-state enable for the B side (high = drive) |
| b_in | input | 16 | Word arriving on the B side |
| ba_hiz | input | 1 | B-to-A high-impedance request |
| ba_pass | input | 1 | B-to-A pass control |
| ba_strobe | input | 1 | B-to-A capture strobe |
| a_out | output | 16 | Word presented to the A side |
| drive_a | output | 1 | Tri-state enable for the A side (high = drive) |

## Verification
Faults in the stored strobe level show up at once as the wrong choice between holding and capturing. A wrong reset value, or a lost low level before pass falls, makes the first rise after that point either load a word it should skip or miss a word it should take. Either way the data output differs one clock after the strobe edge. Faults in the storage word, such as a dropped load, a spurious load or a crossed direction, appear on the data output of the same or the other side one clock after the control that should have loaded it. A drive register that does not follow the high-impedance request is wrong on the very next clock. A long stretch of mixed stimulus compared against an independent model catches faults that only certain control orders expose.

// File: rtl/bdl_pkg.sv
package bdl_pkg;
  localparam int unsigned BDL_WIDTH = 16;

  typedef struct packed {
    logic hiz;
    logic pass;
    logic strobe;
  } bdl_ctl_t;
endpackage

// File: rtl/bdl_edge.sv
module bdl_edge (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic rise
);
  logic strobe_q;

  // Strobe level seen on the previous clock; reset treats it as high.
  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b1;
    else     strobe_q <= strobe;
  end

  assign rise = strobe & ~strobe_q;

  // R5: a rise is a single-clock event
  assert_rise_single_R5: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
  // R10: no rise on the first clock after reset
  assert_no_rise_after_reset_R10: assert property (@(posedge clk)
    $past(rst) |-> !rise);
endmodule

// File: rtl/bdl_store.sv
module bdl_store #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)       q[i] <= 1'b0;
      else if (load) q[i] <= din[i];
    end
  end
endmodule

// File: rtl/bdl_lane.sv
module bdl_lane
  import bdl_pkg::*;
#(
  parameter int unsigned W = BDL_WIDTH
) (
  input  logic         clk,
  input  logic         rst,
  input  bdl_ctl_t     ctl,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         drive
);
  logic rise;
  logic load;

  bdl_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .strobe (ctl.strobe),
    .rise   (rise)
  );

  assign load = ctl.pass | rise;

  bdl_store #(.W(W)) u_store (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .din  (din),
    .q    (dout)
  );

  always_ff @(posedge clk) begin
    if (rst) drive <= 1'b0;
    else     drive <= ~ctl.hiz;
  end

  // R1: reset clears data and drive
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (dout == '0 && !drive));
  // R2: high-impedance request turns drive off
  assert_hiz_off_R2: assert property (@(posedge clk) disable iff (rst)
    ctl.hiz |=> !drive);
  // R4: transparent path
  assert_pass_follow_R4: assert property (@(posedge clk) disable iff (rst)
    ctl.pass |=> dout == $past(din));
  // R5: capture on strobe rise
  assert_capture_R5: assert property (@(posedge clk) disable iff (rst)
    (!ctl.pass && rise) |=> dout == $past(din));
  // R6: hold without a rise
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!ctl.pass && !rise) |=> $stable(dout));
endmodule

// File: rtl/bidir_latch_port.sv
module bidir_latch_port
  import bdl_pkg::*;
#(
  parameter int unsigned W = BDL_WIDTH
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic         ab_hiz,
  input  logic         ab_pass,
  input  logic         ab_strobe,
  output logic [W-1:0] b_out,
  output logic         drive_b,
  input  logic [W-1:0] b_in,
  input  logic         ba_hiz,
  input  logic         ba_pass,
  input  logic         ba_strobe,
  output logic [W-1:0] a_out,
  output logic         drive_a
);
  bdl_ctl_t ab_ctl, ba_ctl;

  assign ab_ctl = '{hiz: ab_hiz, pass: ab_pass, strobe: ab_strobe};
  assign ba_ctl = '{hiz: ba_hiz, pass: ba_pass, strobe: ba_strobe};

  bdl_lane #(.W(W)) u_ab (
    .clk   (clk),
    .rst   (rst),
    .ctl   (ab_ctl),
    .din   (a_in),
    .dout  (b_out),
    .drive (drive_b)
  );

  bdl_lane #(.W(W)) u_ba (
    .clk   (clk),
    .rst   (rst),
    .ctl   (ba_ctl),
    .din   (b_in),
    .dout  (a_out),
    .drive (drive_a)
  );

  // R9: B-to-A activity leaves the B side alone when A-to-B is quiet
  assert_dir_isolated_R9: assert property (@(posedge clk) disable iff (rst)
    (!ab_pass && !ab_strobe) |=> $stable(b_out));
endmodule

// File: tb/bidir_latch_port_bench.sv
`timescale 1ns/1ps
module bidir_latch_port_bench;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_hiz = 1'b1, ab_pass = 1'b0, ab_strobe = 1'b1;
  logic ba_hiz = 1'b1, ba_pass = 1'b0, ba_strobe = 1'b1;
  logic [W-1:0] b_out, a_out;
  logic drive_b, drive_a;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bidir_latch_port #(.W(W)) u_bidir_latch_port (
    .clk(clk), .rst(rst),
    .a_in(a_in), .ab_hiz(ab_hiz), .ab_pass(ab_pass), .ab_strobe(ab_strobe),
    .b_out(b_out), .drive_b(drive_b),
    .b_in(b_in), .ba_hiz(ba_hiz), .ba_pass(ba_pass), .ba_strobe(ba_strobe),
    .a_out(a_out), .drive_a(drive_a)
  );

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    a_in = 16'h1234; b_in = 16'h4321;
    repeat (3) tick();
    chk("R1 b_out in reset", b_out, '0);
    chk("R1 drive_b in reset", {15'd0, drive_b}, 16'd0);
    rst = 1'b0;
    tick(); tick();
    chk("R10 b_out strobe held high", b_out, '0);
    chk("R10 a_out strobe held high", a_out, '0);
    chk("R1 drive_a after reset", {15'd0, drive_a}, 16'd0);
  endtask

  task automatic t_drive();
    ab_hiz = 1'b0;
    tick();
    chk("R3 drive_b on", {15'd0, drive_b}, 16'd1);
    chk("R9 drive_a unaffected", {15'd0, drive_a}, 16'd0);
    ab_hiz = 1'b1; ab_pass = 1'b1; ab_strobe = 1'b0;
    tick();
    chk("R2 drive_b off", {15'd0, drive_b}, 16'd0);
    ab_pass = 1'b0; ab_strobe = 1'b1;
    tick();
    chk("R2 drive_b stays off", {15'd0, drive_b}, 16'd0);
  endtask

  task automatic t_hiz_load();
    ab_hiz = 1'b1; ab_pass = 1'b1; a_in = 16'h7E81;
    tick();
    chk("R11 load while not driving", b_out, 16'h7E81);
    ab_pass = 1'b0; a_in = 16'h0000;
    tick();
    ab_hiz = 1'b0;
    tick();
    chk("R11 word kept on resume", b_out, 16'h7E81);
    chk("R3 drive on resume", {15'd0, drive_b}, 16'd1);
  endtask

  task automatic t_pass();
    ab_hiz = 1'b0; ab_pass = 1'b1;
    a_in = 16'hBEEF; tick(); chk("R4 pass beef", b_out, 16'hBEEF);
    a_in = 16'h0001; tick(); chk("R4 pass 0001", b_out, 16'h0001);
    a_in = 16'hFFFF; tick(); chk("R4 pass ffff", b_out, 16'hFFFF);
  endtask

  task automatic t_fall_high();
    ab_pass = 1'b1; ab_strobe = 1'b1; a_in = 16'h5A5A;
    tick();
    ab_pass = 1'b0; a_in = 16'hFFFF;
    tick();
    chk("R7 hold after fall strobe high", b_out, 16'h5A5A);
    a_in = 16'h1357; tick();
    chk("R6 hold strobe steady high", b_out, 16'h5A5A);
    ab_strobe = 1'b0; a_in = 16'h2468; tick();
    chk("R6 hold on strobe fall", b_out, 16'h5A5A);
    a_in = 16'h9999; tick();
    chk("R6 hold strobe steady low", b_out, 16'h5A5A);
    ab_strobe = 1'b1; a_in = 16'h0F0F; tick();
    chk("R5 capture on rise", b_out, 16'h0F0F);
  endtask

  task automatic t_fall_low();
    ab_pass = 1'b1; ab_strobe = 1'b0; a_in = 16'h1111;
    tick();
    chk("R4 pass before fall", b_out, 16'h1111);
    ab_pass = 1'b0; a_in = 16'h2222;
    tick();
    chk("R6 hold after fall strobe low", b_out, 16'h1111);
    ab_strobe = 1'b1; a_in = 16'h3333;
    tick();
    chk("R8 capture on first rise", b_out, 16'h3333);
  endtask

  task automatic t_indep();
    logic [W-1:0] keep;
    ab_pass = 1'b0; ab_strobe = 1'b1;
    tick();
    keep = b_out;
    ba_hiz = 1'b0; ba_pass = 1'b1; b_in = 16'hC0DE; a_in = 16'hAAAA;
    tick();
    chk("R4 ba pass", a_out, 16'hC0DE);
    chk("R9 b_out unaffected", b_out, keep);
    chk("R3 drive_a on", {15'd0, drive_a}, 16'd1);
    ba_pass = 1'b0; ba_strobe = 1'b0; b_in = 16'h0BAD;
    tick();
    ba_strobe = 1'b1;
    tick();
    chk("R8 ba capture", a_out, 16'h0BAD);
    chk("R9 b_out still unaffected", b_out, keep);
  endtask

  task automatic t_model();
    logic [W-1:0] eb, ea;
    logic pab, pba, edb, eda;
    logic [31:0] lf;
    lf = 32'hACE1_1234;
    ab_pass = 1'b1; ba_pass = 1'b1; ab_strobe = 1'b1; ba_strobe = 1'b1;
    ab_hiz = 1'b0; ba_hiz = 1'b0;
    a_in = 16'h0; b_in = 16'h0;
    tick();
    eb = 16'h0; ea = 16'h0; pab = 1'b1; pba = 1'b1;
    for (int n = 0; n < 400; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      a_in = lf[15:0]; b_in = lf[31:16];
      ab_pass = lf[3] & lf[7]; ab_strobe = lf[9]; ab_hiz = lf[12] & lf[5];
      ba_pass = lf[17] & lf[2]; ba_strobe = lf[20]; ba_hiz = lf[25] & lf[11];
      if (ab_pass || (ab_strobe && !pab)) eb = a_in;
      if (ba_pass || (ba_strobe && !pba)) ea = b_in;
      pab = ab_strobe; pba = ba_strobe;
      edb = ~ab_hiz; eda = ~ba_hiz;
      tick();
      chk("R5 model b_out", b_out, eb);
      chk("R5 model a_out", a_out, ea);
      chk("R3 model drive_b", {15'd0, drive_b}, {15'd0, edb});
      chk("R2 model drive_a", {15'd0, drive_a}, {15'd0, eda});
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_drive();
    t_hiz_load();
    t_pass();
    t_fall_high();
    t_fall_low();
    t_indep();
    t_model();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule